// File: doc/BRIEF.md
# Bus Channel Interrupt Status Controller

This block keeps the interrupt enable register, the sticky interrupt status register and the interrupt line for a single serial bus channel. The transfer engine reports what happened on the bus through single-cycle event pulses: address or data acknowledged, not acknowledged, a byte received, a clean stop, and a stop that was requested while the channel was not active. Each pulse sets its own status bit, and the bit stays set until software clears it.

When the engine asks for an interrupt, the status register is pruned by the enable mask at that moment. If anything survives, the interrupt line and the channel's pending bit (used by a controller-level summary) assert. Software clears status bits by writing ones. A write that leaves the register empty drops the line. If software acknowledges a received byte while a receive command is still outstanding, the block asks the engine to receive again. It marks the byte as received and raises the interrupt once more in the same step.

Top module: `bus_irq_ctrl`

## Requirements
- R1: After reset the enable register, the status register, `irq`, `pend` and `rx_restart` are all zero.
- R2: A write with `wr_sel`=0 loads the enable register from `wr_data[14:0]`. Reading with `rd_sel`=0 returns it, with bits 31..15 zero.
- R3: Event pulses set sticky status bits. `ev_ack` sets bit 0, `ev_nak` bit 1, `ev_rxdone` bit 2, `ev_stop_bad` bit 3 and `ev_stop_ok` bit 4. A bit stays set until it is cleared.
- R4: A write with `wr_sel`=1 clears every status bit whose position in `wr_data[14:0]` holds a one. Other status bits are left unchanged, and `wr_data[31:15]` has no effect.
- R5: An event pulse in the same cycle as a clearing write on its bit leaves that bit set.
- R6: On `raise_req`, the status register becomes its value ANDed with the enable register, including any events that arrive in the same cycle. If the result is nonzero, `irq` and `pend` are 1 from the next cycle.
- R7: `irq` and `pend` drop only when a status write leaves the status register zero. Otherwise they keep their value.
- R8: A status write that clears bit 2 while bit 2 is set and `rx_pending` is 1 does three things. It pulses `rx_restart` high for the following cycle. It sets bit 2 again. It applies a raise as in R6.
- R9: Reading with `rd_sel`=1 returns the full status value, including bits that are not enabled, with bits 31..15 zero.
- R10: A raise whose masked result is zero does not assert `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ack | input | 1 | Transmit acknowledged pulse |
| ev_nak | input | 1 | Transmit not acknowledged pulse |
| ev_rxdone | input | 1 | Byte received pulse |
| ev_stop_bad | input | 1 | Stop requested while inactive pulse |
| ev_stop_ok | input | 1 | Normal stop pulse |
| raise_req | input | 1 | Engine interrupt request |
| rx_pending | input | 1 | A receive command is still outstanding |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enable, 1 status |
| wr_data | input | DW | Write data |
| rd_sel | input | 1 | Read target: 0 enable, 1 status |
| rd_data | output | DW | Read data |
| irq | output | 1 | Channel interrupt line |
| pend | output | 1 | Channel pending bit for the summary |
| rx_restart | output | 1 | Request to the engine to receive again |

## Verification
The in-line assertions check on every cycle that events stick, that a raise leaves no disabled bit set, that a surviving raise turns the line on, and that the line holds until a status write. They also check that a clear without competing events actually clears, and that a restart request only follows a qualifying write. The bench sweeps every enable mask against every event combination. It is the only place where exact read values, the event-over-clear collision, partial clears that keep the line up, and the complete restart sequence are shown.

// File: rtl/bus_irq_ctrl.sv
module bus_irq_ctrl #(
  parameter int DW = 32,
  parameter int SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_ack,
  input  logic          ev_nak,
  input  logic          ev_rxdone,
  input  logic          ev_stop_bad,
  input  logic          ev_stop_ok,
  input  logic          raise_req,
  input  logic          rx_pending,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          pend,
  output logic          rx_restart
);
  localparam int RXB = 2;

  logic [SW-1:0] en_q, st_q, ev_vec, clr, st_clr, st_ev, st_nx;
  logic          wr_st, wr_en_reg, restart, raise, irq_q;

  assign ev_vec = SW'({ev_stop_ok, ev_stop_bad, ev_rxdone, ev_nak, ev_ack});
  assign wr_st     = wr_en && wr_sel;
  assign wr_en_reg = wr_en && !wr_sel;
  assign clr       = wr_st ? wr_data[SW-1:0] : '0;
  assign restart   = wr_st && st_q[RXB] && wr_data[RXB] && rx_pending;
  assign raise     = raise_req || restart;

  assign st_clr = st_q & ~clr;
  assign st_ev  = st_clr | ev_vec | (restart ? SW'(1) << RXB : '0);
  assign st_nx  = raise ? (st_ev & en_q) : st_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '0;
      st_q       <= '0;
      irq_q      <= 1'b0;
      rx_restart <= 1'b0;
    end else begin
      if (wr_en_reg) en_q <= wr_data[SW-1:0];
      st_q       <= st_nx;
      rx_restart <= restart;
      if (raise && (st_nx != '0)) irq_q <= 1'b1;
      else if (wr_st && (st_nx == '0)) irq_q <= 1'b0;
    end
  end

  assign irq     = irq_q;
  assign pend    = irq_q;
  assign rd_data = DW'(rd_sel ? st_q : en_q);

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && !raise_req) |=> st_q[0]); // R3
  AST_RAISE_PRUNES: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req && !wr_en_reg) |=> ((st_q & ~en_q) == '0)); // R6
  AST_RAISE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req && (((st_q | ev_vec) & en_q) != '0) && !wr_st) |=> (irq && pend)); // R6
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_st) |=> irq); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && ev_vec == '0 && !rx_pending) |=> ((st_q & $past(wr_data[SW-1:0])) == '0)); // R4
  AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_restart) |-> $past(wr_st && wr_data[RXB] && rx_pending)); // R8
endmodule

// File: tb/bus_irq_ctrl_test.sv
module bus_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic ev_ack = 0, ev_nak = 0, ev_rxdone = 0, ev_stop_bad = 0, ev_stop_ok = 0;
  logic raise_req = 0, rx_pending = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq, pend, rx_restart;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bus_irq_ctrl uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_ev(logic [4:0] v);
    {ev_stop_ok, ev_stop_bad, ev_rxdone, ev_nak, ev_ack} = v;
  endtask

  task automatic rd(logic sel, output logic [31:0] v);
    rd_sel = sel; #0.5; v = rd_data;
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick(); tick(); rst_n = 1; #0.5;
    // R1 reset state
    rd(0, v); chk("R1 enable", v, 0);
    rd(1, v); chk("R1 status", v, 0);
    chk("R1 line", {irq, pend, rx_restart}, 0);

    // R2 enable width
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 enable mask", v, 32'h7FFF);

    // R3 R6 R9 R10 sweep of all masks against all events
    for (int m = 0; m < 32; m++) begin
      for (int e = 0; e < 32; e++) begin
        wr(0, m);
        wr(1, 32'hFFFF_FFFF);
        rd(1, v); chk("R4 full clear", v, 0);
        chk("R7 line drops", {irq, pend}, 0);
        set_ev(e); tick(); set_ev(0);
        rd(1, v); chk("R3 R9 sticky full read", v, e);
        chk("R10 no raise no line", irq, 0);
        raise_req = 1; tick(); raise_req = 0;
        rd(1, v); chk("R6 masked status", v, e & m);
        chk("R6 R10 line", {irq, pend}, ((e & m) != 0) ? 2'b11 : 2'b00);
      end
    end

    // R4 partial clear keeps the line (R7)
    wr(0, 32'h1F);
    set_ev(5'h1F); raise_req = 1; tick(); raise_req = 0; set_ev(0);
    wr(1, 32'hFFFF_0003);
    rd(1, v); chk("R4 partial clear", v, 32'h1C);
    chk("R7 line kept", irq, 1);

    // R5 event beats clear
    set_ev(5'h01); wr(1, 32'h1F); set_ev(0);
    rd(1, v); chk("R5 event wins", v, 32'h01);
    chk("R7 line kept nonzero", irq, 1);
    wr(1, 32'h01); chk("R7 line drops", irq, 0);

    // R8 restart with receive pending
    wr(0, 32'h04);
    set_ev(5'h04); raise_req = 1; tick(); raise_req = 0; set_ev(0);
    chk("R8 setup line", irq, 1);
    rx_pending = 1;
    wr(1, 32'h04);
    rd(1, v); chk("R8 rx bit back", v, 32'h04);
    chk("R8 line up", irq, 1);
    chk("R8 restart pulse", rx_restart, 1);
    rx_pending = 0; tick();
    chk("R8 pulse ends", rx_restart, 0);

    // R8 no restart without pending receive
    wr(1, 32'h04);
    rd(1, v); chk("R8 cleared", v, 0);
    chk("R8 line down", irq, 0);
    tick();
    chk("R8 no pulse", rx_restart, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule